// File: doc/BRIEF.md
# Beat-to-Qword Write Bridge with Rewind

This block gathers a stream of 32-bit beats into 128-bit memory writes. Four accepted beats make one qword: the first beat fills the lowest four bytes. A beat marked last closes the qword early. The finished qword leaves the block as a single-cycle write strobe with an address, the data and a 16-bit byte-enable. The address is a fixed base plus a running offset, and that offset moves forward one qword per write. A long transfer therefore lands in consecutive 16-byte slots.

A producer that wants one fixed mailbox slot pulses the rewind input while no qword is half built. The offset then returns to zero, and the next write overwrites the slot at the base address. A sticky flag goes high once any last beat has been accepted. Only reset clears it; rewind does not. A rewind given while a qword is partly filled is still applied, but a bound checker reports it as misuse. When rewind is tied low, the block is a plain streaming packer.

Top module: `beat_qword_writer`

## Requirements
- R1: Reset clears the offset, the partial qword, the beat position and the last-seen flag. After reset, no write is issued and the next write lands at the base address.
- R2: Beats accepted in order k = 0..3 occupy data bits [32k+31:32k] of the qword. The write strobe is high for exactly the one cycle after the fourth beat is accepted, and never after the first three.
- R3: Each write targets base address + offset. The base defaults to 0x0008_0000. Without rewind, the offset grows by 16 after every write, so successive writes go to base, base+0x10, base+0x20 and so on.
- R4: A qword completed by its fourth beat is written with byte-enable 16'hFFFF.
- R5: A last beat at position p < 3 emits at once. The byte-enable covers only lanes 0..p (lane k is bits [4k+3:4k]), and the unfilled data lanes read zero.
- R6: When rewind is high at a clock edge, the offset is 0 after that edge. A write triggered at the same edge still uses the offset from before the rewind. The next write goes to base + 0.
- R7: After every write, the partial data, the byte-enables and the beat position are clear. The next accepted beat fills lane 0.
- R8: The last-seen output is high from the cycle after a last beat is accepted. It stays high through further traffic and through rewind, and only reset lowers it.
- R9: Rewind is legal only while no qword is partly filled (beat position 0). Misuse is reported by a simulation-only check, but the rewind still takes effect.
- R10: Beat data and the last marker are ignored while beat_valid_i is low. They cause no write and change no lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_valid_i | input | 1 | Beat present; accepted on every clock edge where it is high |
| beat_data_i | input | 32 | Beat payload |
| beat_last_i | input | 1 | Beat closes the transfer |
| rewind_i | input | 1 | Return the offset to zero; tie low for pure streaming |
| wr_en_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 32 | Write byte address (base + offset) |
| wr_data_o | output | 128 | Packed qword, beat 0 in the low bytes |
| wr_be_o | output | 16 | Byte-enable of the write |
| last_seen_o | output | 1 | Sticky: a last beat has been accepted |

## Verification
The interesting collision is a rewind landing on the same edge as a write trigger. One case sends a single-beat last at position 0 with rewind high. The write must still use the old offset, and the following qword must go to base + 0. A second case raises rewind together with the first beat of a full qword, so the write three cycles later must already see offset zero. A behavioural model in the bench predicts every output on every cycle, and directed checks pin the exact addresses, enables and data in both collision cases.

// File: rtl/bqw_pkg.sv
package bqw_pkg;
  // why the packer closes a qword in the current cycle
  typedef enum logic [1:0] {
    EMIT_NONE  = 2'd0,
    EMIT_FULL  = 2'd1,
    EMIT_SHORT = 2'd2
  } emit_kind_t;
endpackage

// File: rtl/bqw_pack.sv
module bqw_pack
  import bqw_pkg::*;
#(
  parameter int BEAT_W = 32,
  parameter int BEATS  = 4,
  localparam int LANE_BE = BEAT_W / 8,
  localparam int QW_W    = BEAT_W * BEATS,
  localparam int BE_W    = QW_W / 8,
  localparam int POS_W   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_valid_i,
  input  logic [BEAT_W-1:0] beat_data_i,
  input  logic              beat_last_i,
  output emit_kind_t        kind_o,
  output logic [QW_W-1:0]   qw_data_o,
  output logic [BE_W-1:0]   qw_be_o,
  output logic [POS_W-1:0]  pos_o
);
  logic [POS_W-1:0] pos_q;
  logic             at_top;
  logic             fire;

  assign at_top = (pos_q == POS_W'(BEATS - 1));
  assign pos_o  = pos_q;

  always_comb begin
    if (!beat_valid_i)    kind_o = EMIT_NONE;
    else if (at_top)      kind_o = EMIT_FULL;
    else if (beat_last_i) kind_o = EMIT_SHORT;
    else                  kind_o = EMIT_NONE;
  end

  assign fire = (kind_o != EMIT_NONE);

  always_ff @(posedge clk) begin
    if (rst || fire)       pos_q <= '0;
    else if (beat_valid_i) pos_q <= pos_q + POS_W'(1);
  end

  // one storage lane per beat; incoming beat merged into the output path
  for (genvar g = 0; g < BEATS; g++) begin : g_lane
    logic              hit;
    logic [BEAT_W-1:0] lane_q;
    logic              full_q;

    assign hit = beat_valid_i && (pos_q == POS_W'(g));
    assign qw_data_o[g*BEAT_W +: BEAT_W] = hit ? beat_data_i : lane_q;
    assign qw_be_o[g*LANE_BE +: LANE_BE] = (hit || full_q) ? {LANE_BE{1'b1}} : {LANE_BE{1'b0}};

    always_ff @(posedge clk) begin
      if (rst || fire) begin
        lane_q <= '0;
        full_q <= 1'b0;
      end else if (hit) begin
        lane_q <= beat_data_i;
        full_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bqw_offset.sv
module bqw_offset #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance_i,
  input  logic              rewind_i,
  output logic [ADDR_W-1:0] offset_o
);
  // rewind outranks advance at the same edge
  always_ff @(posedge clk) begin
    if (rst || rewind_i) offset_o <= '0;
    else if (advance_i)  offset_o <= offset_o + ADDR_W'(STEP);
  end
endmodule

// File: rtl/bqw_emit_reg.sv
module bqw_emit_reg #(
  parameter int          ADDR_W    = 32,
  parameter int          QW_W      = 128,
  parameter logic [31:0] BASE_ADDR = 32'h0008_0000,
  localparam int BE_W = QW_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [QW_W-1:0]   data_i,
  input  logic [BE_W-1:0]   be_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [QW_W-1:0]   wr_data_o,
  output logic [BE_W-1:0]   wr_be_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      wr_be_o   <= '0;
    end else begin
      wr_en_o <= fire_i;
      if (fire_i) begin
        wr_addr_o <= ADDR_W'(BASE_ADDR) + offset_i;
        wr_data_o <= data_i;
        wr_be_o   <= be_i;
      end
    end
  end
endmodule

// File: rtl/beat_qword_writer.sv
module beat_qword_writer
  import bqw_pkg::*;
#(
  parameter int          BEAT_W    = 32,
  parameter int          BEATS     = 4,
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0008_0000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      beat_valid_i,
  input  logic [BEAT_W-1:0]         beat_data_i,
  input  logic                      beat_last_i,
  input  logic                      rewind_i,
  output logic                      wr_en_o,
  output logic [ADDR_W-1:0]         wr_addr_o,
  output logic [BEAT_W*BEATS-1:0]   wr_data_o,
  output logic [BEAT_W*BEATS/8-1:0] wr_be_o,
  output logic                      last_seen_o
);
  localparam int QW_W  = BEAT_W * BEATS;
  localparam int BE_W  = QW_W / 8;
  localparam int POS_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  emit_kind_t        kind_w;
  logic [QW_W-1:0]   qw_data_w;
  logic [BE_W-1:0]   qw_be_w;
  logic [POS_W-1:0]  pos_w;
  logic [ADDR_W-1:0] offset_w;
  logic              fire_w;

  bqw_pack #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_pack (
    .clk(clk), .rst(rst),
    .beat_valid_i(beat_valid_i), .beat_data_i(beat_data_i), .beat_last_i(beat_last_i),
    .kind_o(kind_w), .qw_data_o(qw_data_w), .qw_be_o(qw_be_w), .pos_o(pos_w)
  );

  assign fire_w = (kind_w != EMIT_NONE);

  bqw_offset #(.ADDR_W(ADDR_W), .STEP(BE_W)) u_offset (
    .clk(clk), .rst(rst),
    .advance_i(fire_w), .rewind_i(rewind_i), .offset_o(offset_w)
  );

  bqw_emit_reg #(.ADDR_W(ADDR_W), .QW_W(QW_W), .BASE_ADDR(BASE_ADDR)) u_emit (
    .clk(clk), .rst(rst),
    .fire_i(fire_w), .offset_i(offset_w), .data_i(qw_data_w), .be_i(qw_be_w),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_be_o(wr_be_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                              last_seen_o <= 1'b0;
    else if (beat_valid_i && beat_last_i) last_seen_o <= 1'b1;
  end
endmodule

// File: rtl/bqw_checker.sv
module bqw_checker #(
  parameter int BEATS  = 4,
  parameter int ADDR_W = 32,
  parameter int BE_W   = 16,
  localparam int POS_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              beat_valid_i,
  input logic              beat_last_i,
  input logic              rewind_i,
  input logic [POS_W-1:0]  pos_w,
  input logic [ADDR_W-1:0] offset_w,
  input logic              wr_en_o,
  input logic [BE_W-1:0]   wr_be_o,
  input logic              last_seen_o
);
  logic trig;
  assign trig = beat_valid_i && (beat_last_i || pos_w == POS_W'(BEATS - 1));

  p_full_be_r4: assert property (@(posedge clk) disable iff (rst)
    (beat_valid_i && pos_w == POS_W'(BEATS - 1)) |=> (wr_en_o && wr_be_o == {BE_W{1'b1}}));

  p_lane0_be_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (wr_be_o[3:0] == 4'hF));

  p_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (trig && !rewind_i) |=> (offset_w == $past(offset_w) + ADDR_W'(BE_W)));

  p_rewind_zero_r6: assert property (@(posedge clk) disable iff (rst)
    rewind_i |=> (offset_w == '0));

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    last_seen_o |=> last_seen_o);

  p_last_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (beat_valid_i && beat_last_i) |=> last_seen_o);

  p_no_beat_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    !beat_valid_i |=> !wr_en_o);

  // simulation-only misuse report; the design still applies the rewind
  p_rewind_idle_r9: assert property (@(posedge clk) disable iff (rst)
    rewind_i |-> (pos_w == '0));
endmodule

bind beat_qword_writer bqw_checker #(.BEATS(BEATS), .ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (
  .clk(clk), .rst(rst), .beat_valid_i(beat_valid_i), .beat_last_i(beat_last_i),
  .rewind_i(rewind_i), .pos_w(pos_w), .offset_w(offset_w), .wr_en_o(wr_en_o),
  .wr_be_o(wr_be_o), .last_seen_o(last_seen_o)
);

// File: tb/sim_beat_qword_writer.sv
`timescale 1ns/1ps
module sim_beat_qword_writer;
  localparam logic [31:0] BASE = 32'h0008_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bv = 1'b0, bl = 1'b0, rw = 1'b0;
  logic [31:0] bd = '0;
  logic wr_en, last_seen;
  logic [31:0] wr_addr;
  logic [127:0] wr_data;
  logic [15:0] wr_be;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  beat_qword_writer u0 (
    .clk(clk), .rst(rst), .beat_valid_i(bv), .beat_data_i(bd), .beat_last_i(bl),
    .rewind_i(rw), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_be_o(wr_be), .last_seen_o(last_seen)
  );

  // behavioural reference: byte lists and integers
  byte unsigned m_bytes[$];
  longint unsigned m_off;
  bit m_wr, m_ls;
  longint unsigned m_addr;
  logic [127:0] m_data;
  logic [15:0] m_be;

  always @(posedge clk) begin
    if (rst) begin
      m_bytes.delete(); m_off = 0; m_wr = 0; m_ls = 0;
    end else begin
      m_wr = 0;
      if (bv) begin
        for (int i = 0; i < 4; i++) m_bytes.push_back(8'((bd >> (8*i)) & 32'hFF));
        if (bl || m_bytes.size() == 16) begin
          m_wr = 1;
          m_addr = (BASE + m_off) & 32'hFFFF_FFFF;
          m_data = '0; m_be = '0;
          for (int i = 0; i < m_bytes.size(); i++) begin
            m_data[8*i +: 8] = m_bytes[i];
            m_be[i] = 1'b1;
          end
          m_bytes.delete();
          m_off = m_off + 16;
        end
        if (bl) m_ls = 1;
      end
      if (rw) m_off = 0;
    end
  end

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && cycles > 0) begin
      check({cur_req, " model wr_en"}, 128'(wr_en), 128'(m_wr));
      check({cur_req, " model last_seen"}, 128'(last_seen), 128'(m_ls));
      if (m_wr) begin
        check({cur_req, " model addr"}, 128'(wr_addr), 128'(m_addr));
        check({cur_req, " model data"}, wr_data, m_data);
        check({cur_req, " model be"}, 128'(wr_be), 128'(m_be));
      end
    end
  end

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      finish_run();
    end
  end

  task automatic step(logic v, logic [31:0] d, logic l, logic r);
    bv = v; bd = d; bl = l; rw = r;
    @(negedge clk);
    bv = 1'b0; bl = 1'b0; rw = 1'b0;
  endtask

  task automatic full_qword(logic [31:0] seed, logic rw_first);
    step(1, seed, 0, rw_first);
    step(1, seed + 32'h0404_0404, 0, 0);
    step(1, seed + 32'h0808_0808, 0, 0);
    step(1, seed + 32'h0C0C_0C0C, 0, 0);
  endtask

  task automatic expect_wr(string req, logic [31:0] a, logic [15:0] be);
    check({req, " wr_en"}, 128'(wr_en), 128'(1));
    check({req, " addr"}, 128'(wr_addr), 128'(a));
    check({req, " be"}, 128'(wr_be), 128'(be));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    check("R1 reset wr_en", 128'(wr_en), 128'(0));
    check("R1 reset last_seen", 128'(last_seen), 128'(0));

    cur_req = "R2";
    step(1, 32'h0302_0100, 0, 0);
    check("R2 no write after beat 1", 128'(wr_en), 128'(0));
    step(1, 32'h0706_0504, 0, 0);
    step(1, 32'h0B0A_0908, 0, 0);
    check("R2 no write after beat 3", 128'(wr_en), 128'(0));
    step(1, 32'h0F0E_0D0C, 0, 0);
    expect_wr("R2 R3 R4 first qword", BASE, 16'hFFFF);
    check("R2 packing", wr_data, 128'h0F0E0D0C_0B0A0908_07060504_03020100);
    step(0, 0, 0, 0);
    check("R2 strobe one cycle", 128'(wr_en), 128'(0));

    cur_req = "R10";
    step(0, 32'hDEAD_BEEF, 1, 0);
    check("R10 ignored last", 128'(last_seen), 128'(0));
    step(0, 32'hCAFE_F00D, 0, 0);
    check("R10 no write", 128'(wr_en), 128'(0));
    cur_req = "R3";
    full_qword(32'h1111_1111, 0);
    expect_wr("R3 second slot", BASE + 32'h10, 16'hFFFF);
    check("R10 lanes clean", wr_data, 128'h1D1D1D1D_19191919_15151515_11111111);

    cur_req = "R5";
    step(1, 32'hA0A0_A0A0, 0, 0);
    step(1, 32'hB0B0_B0B0, 1, 0);
    expect_wr("R5 short qword", BASE + 32'h20, 16'h00FF);
    check("R5 short data", wr_data, {64'h0, 32'hB0B0_B0B0, 32'hA0A0_A0A0});
    check("R8 last_seen rises", 128'(last_seen), 128'(1));

    cur_req = "R7";
    full_qword(32'h2020_2020, 0);
    expect_wr("R7 after short", BASE + 32'h30, 16'hFFFF);
    check("R7 lane 0 restart", 128'(wr_data[31:0]), 128'(32'h2020_2020));

    cur_req = "R6";
    step(0, 0, 0, 1);
    full_qword(32'h3030_3030, 0);
    expect_wr("R6 idle rewind", BASE, 16'hFFFF);
    check("R8 survives rewind", 128'(last_seen), 128'(1));

    step(1, 32'h4444_4444, 1, 1);
    expect_wr("R6 same-edge emit uses old offset", BASE + 32'h10, 16'h000F);
    full_qword(32'h5050_5050, 0);
    expect_wr("R6 next after same-edge", BASE, 16'hFFFF);

    full_qword(32'h6060_6060, 1);
    expect_wr("R6 rewind with first beat", BASE, 16'hFFFF);

    cur_req = "R3";
    full_qword(32'h7070_7070, 0);
    expect_wr("R3 stream a", BASE + 32'h10, 16'hFFFF);
    full_qword(32'h8080_8080, 0);
    expect_wr("R3 stream b", BASE + 32'h20, 16'hFFFF);
    step(1, 32'h9090_9090, 1, 0);
    step(1, 32'h9191_9191, 1, 0);
    expect_wr("R3 back-to-back single", BASE + 32'h40, 16'h000F);

    cur_req = "R1";
    step(1, 32'hEEEE_EEEE, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset clears last_seen", 128'(last_seen), 128'(0));
    full_qword(32'h0101_0101, 0);
    expect_wr("R1 base after reset", BASE, 16'hFFFF);
    check("R1 partial dropped", 128'(wr_data[31:0]), 128'(32'h0101_0101));

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule